// File: doc/BRIEF.md
# Glitch-free synchronous clock stop controller

This block sits after the clock synthesizer and decides, for every generated clock output, whether it runs or rests low. Each output has its own enable bit from the configuration registers, and two active-low stop pins can additionally halt whole groups. One pin halts the processor and graphics clocks. The other halts the five gated bus clocks. The free-running bus clock and all other outputs are not affected by either pin.

A stop or restart request is first captured on a rising edge of the free-running bus clock. It then reaches each output through a flop clocked on that output's own falling edge. As a result, a stopping clock always completes its last high phase, it rests low while stopped, and it restarts with a high phase of full width.

A power-management strap is captured while reset is held. With the strap at 0, two shared pads act as the stop inputs and their memory-clock function is silenced. With the strap at 1, the pads carry memory clocks and both stop functions are inactive. A global tristate control releases every output enable without disturbing the gating state.

Top module: `clkstop_ctrl`

## Requirements
- R1: While rst_n is low, every gated clock output stays low.
- R2: An output toggles only when its enable bit is 1 and no active stop applies to its group. An output whose enable bit is 0 stays low.
- R3: With the strap latched at 0, cpu_stop_n low stops all cpu_clk and agp_clk outputs, and every other output keeps its state.
- R4: With the strap latched at 0, pci_stop_n low stops pci_clk[N_PCI-1:0]. pcif_clk and all other outputs keep running.
- R5: strap_mode is latched only while rst_n is low. With the latched value 1, both stop pins are ignored, oe_shared is 1 and the top two bits of sdram_clk (N_SDRAM-1 and N_SDRAM-2) run. With the latched value 0, those two bits stay low and oe_shared is 0.
- R6: A change on a stop pin has no effect on any output before the next rising edge of pci_free_clk, and no effect on a target output before that output's following falling edge.
- R7: A stopped output rests low. Every high and low phase of a gated output lasts at least half of its source period, including the last phase before a stop and the first phase after a restart.
- R8: Measured from the rising edge of pci_free_clk that samples the stop pins, the CPU group stops or resumes within 2 CPU source periods and the PCI group within 1 PCI source period.
- R9: tri_all high drives oe_main and oe_shared to 0 and leaves the gated clocks running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low reset; the strap is captured while it is low |
| pci_free_clk | input | 1 | Free-running bus clock; samples the stop pins and sources pcif_clk |
| cpu_src_clk | input | 1 | Processor clock source |
| agp_src_clk | input | 1 | Graphics clock source |
| pci_src_clk | input | 1 | Gated bus clock source |
| sdram_src_clk | input | 1 | Memory clock source |
| ref_src_clk | input | 1 | Reference clock source |
| strap_mode | input | 1 | Power-management strap: 0 = pads are stop inputs, 1 = pads are memory clocks |
| cpu_stop_n | input | 1 | Active-low stop for the processor and graphics groups |
| pci_stop_n | input | 1 | Active-low stop for the gated bus clocks |
| tri_all | input | 1 | Releases all output enables |
| en_cpu | input | N_CPU | Per-output enable bits, processor group |
| en_agp | input | N_AGP | Per-output enable bits, graphics group |
| en_pci | input | N_PCI | Per-output enable bits, gated bus group |
| en_pcif | input | 1 | Enable bit of the free-running bus clock output |
| en_sdram | input | N_SDRAM | Per-output enable bits, memory group |
| en_ref | input | N_REF | Per-output enable bits, reference group |
| cpu_clk | output | N_CPU | Gated processor clocks |
| agp_clk | output | N_AGP | Gated graphics clocks |
| pci_clk | output | N_PCI | Gated bus clocks |
| pcif_clk | output | 1 | Free-running bus clock output |
| sdram_clk | output | N_SDRAM | Gated memory clocks; the top two share pads with the stop pins |
| ref_clk | output | N_REF | Gated reference clocks |
| oe_main | output | 1 | Output enable of all dedicated clock pads |
| oe_shared | output | 1 | Output enable of the two shared pads |

## Verification
A table walk applies every combination of the two stop pins together with full, empty, alternating and mixed enable patterns. Each pattern separates the AND of enable and stop from an OR, shows which group each pin reaches, and confirms that the free-running bus clock is immune to the bus stop. Directed sequences place a stop and a restart right after a sampling edge and probe the outputs just before and just after the expected falling edge, which tells a correct one-edge path from a bypassed or doubled one. A strap-1 reset with both pins held low shows that the pins are then ignored. Pulse-width monitors on each group catch any truncated or runt phase.

// File: rtl/clkstop_pkg.sv
// Shared types for the clock stop controller.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package clkstop_pkg;
    // Group run flags as sampled on the free-running bus clock.
    typedef struct packed {
        logic cpu_run;
        logic pci_run;
    } stop_state_t;

    // Number of memory-clock pads shared with the stop pins.
    localparam int unsigned SHARED_PADS = 2;
endpackage

// File: rtl/clkstop_sampler.sv
// Captures the strap during reset and samples the two stop pins on the
// free-running bus clock. A latched strap of 1 masks both pins.
// Assumes: stop pins are driven synchronously to pci_free_clk.
module clkstop_sampler
    import clkstop_pkg::*;
(
    input  logic        pci_free_clk,
    input  logic        rst_n,
    input  logic        strap_mode,
    input  logic        cpu_stop_n,
    input  logic        pci_stop_n,
    output logic        mode_q,
    output stop_state_t run_s
);
    // Strap capture in reset, stop sampling afterwards.
    always_ff @(posedge pci_free_clk) begin
        if (!rst_n) begin
            mode_q <= strap_mode;
            run_s  <= '0;
        end else begin
            run_s.cpu_run <= mode_q | cpu_stop_n;
            run_s.pci_run <= mode_q | pci_stop_n;
        end
    end
endmodule

// File: rtl/clkstop_gate.sv
// Bank of W glitch-free clock gates sharing one source clock. Each gate
// holds an enable flop loaded on the falling edge of the source, so the
// output only opens or closes while the source is low.
// Assumes: run_req is stable around the falling edge of src_clk.
module clkstop_gate #(
    parameter int unsigned W = 1
) (
    input  logic         src_clk,
    input  logic         rst_n,
    input  logic [W-1:0] run_req,
    output logic [W-1:0] gclk
);
    logic [W-1:0] en_q;

    for (genvar g = 0; g < W; g++) begin : g_gate
        // Falling-edge enable load; cleared in reset.
        always_ff @(negedge src_clk) begin
            if (!rst_n) en_q[g] <= 1'b0;
            else        en_q[g] <= run_req[g];
        end
        assign gclk[g] = src_clk & en_q[g];
    end
endmodule

// File: rtl/clkstop_ctrl.sv
// Top of the clock stop controller: combines register enables with the
// sampled group stops and drives one gate bank per source clock.
// Assumes: all source clocks run while rst_n is low for several cycles.
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int unsigned N_CPU   = 4,
    parameter int unsigned N_AGP   = 2,
    parameter int unsigned N_PCI   = 5,
    parameter int unsigned N_SDRAM = 12,
    parameter int unsigned N_REF   = 2
) (
    input  logic               rst_n,
    input  logic               pci_free_clk,
    input  logic               cpu_src_clk,
    input  logic               agp_src_clk,
    input  logic               pci_src_clk,
    input  logic               sdram_src_clk,
    input  logic               ref_src_clk,
    input  logic               strap_mode,
    input  logic               cpu_stop_n,
    input  logic               pci_stop_n,
    input  logic               tri_all,
    input  logic [N_CPU-1:0]   en_cpu,
    input  logic [N_AGP-1:0]   en_agp,
    input  logic [N_PCI-1:0]   en_pci,
    input  logic               en_pcif,
    input  logic [N_SDRAM-1:0] en_sdram,
    input  logic [N_REF-1:0]   en_ref,
    output logic [N_CPU-1:0]   cpu_clk,
    output logic [N_AGP-1:0]   agp_clk,
    output logic [N_PCI-1:0]   pci_clk,
    output logic               pcif_clk,
    output logic [N_SDRAM-1:0] sdram_clk,
    output logic [N_REF-1:0]   ref_clk,
    output logic               oe_main,
    output logic               oe_shared
);
    localparam int unsigned N_FIXED = N_SDRAM - SHARED_PADS;

    logic               mode_q;
    stop_state_t        run_s;
    logic               cpu_run;
    logic               pci_run;
    logic [N_SDRAM-1:0] sd_mask;

    clkstop_sampler u_sampler (
        .pci_free_clk (pci_free_clk),
        .rst_n        (rst_n),
        .strap_mode   (strap_mode),
        .cpu_stop_n   (cpu_stop_n),
        .pci_stop_n   (pci_stop_n),
        .mode_q       (mode_q),
        .run_s        (run_s)
    );

    assign cpu_run = run_s.cpu_run;
    assign pci_run = run_s.pci_run;
    // Shared pads carry memory clocks only in strap mode 1.
    assign sd_mask = {{SHARED_PADS{mode_q}}, {N_FIXED{1'b1}}};

    clkstop_gate #(.W(N_CPU)) u_cpu (
        .src_clk (cpu_src_clk), .rst_n (rst_n),
        .run_req (en_cpu & {N_CPU{cpu_run}}), .gclk (cpu_clk)
    );
    clkstop_gate #(.W(N_AGP)) u_agp (
        .src_clk (agp_src_clk), .rst_n (rst_n),
        .run_req (en_agp & {N_AGP{cpu_run}}), .gclk (agp_clk)
    );
    clkstop_gate #(.W(N_PCI)) u_pci (
        .src_clk (pci_src_clk), .rst_n (rst_n),
        .run_req (en_pci & {N_PCI{pci_run}}), .gclk (pci_clk)
    );
    clkstop_gate #(.W(1)) u_pcif (
        .src_clk (pci_free_clk), .rst_n (rst_n),
        .run_req (en_pcif), .gclk (pcif_clk)
    );
    clkstop_gate #(.W(N_SDRAM)) u_sdram (
        .src_clk (sdram_src_clk), .rst_n (rst_n),
        .run_req (en_sdram & sd_mask), .gclk (sdram_clk)
    );
    clkstop_gate #(.W(N_REF)) u_ref (
        .src_clk (ref_src_clk), .rst_n (rst_n),
        .run_req (en_ref), .gclk (ref_clk)
    );

    // Pad enables: global tristate wins; shared pads also need mode 1.
    assign oe_main   = ~tri_all;
    assign oe_shared = ~tri_all & mode_q;
endmodule

// File: rtl/clkstop_ctrl_chk.sv
// Assertion checker for clkstop_ctrl, attached with bind below.
// Assumes: observes the first output of the CPU and PCI groups.
module clkstop_ctrl_chk (
    input logic       rst_n,
    input logic       pci_free_clk,
    input logic       cpu_src_clk,
    input logic       pci_src_clk,
    input logic       cpu_stop_n,
    input logic       pci_stop_n,
    input logic       mode_q,
    input logic       cpu_run,
    input logic       pci_run,
    input logic       en_cpu0,
    input logic       cpu_clk0,
    input logic       en_pci0,
    input logic       pci_clk0,
    input logic [1:0] sd_shared,
    input logic       oe_shared
);
    a_r5_mode_masks_stops: assert property (@(posedge pci_free_clk) disable iff (!rst_n)
        mode_q |=> (cpu_run && pci_run));

    a_r3_cpu_stop_sampled: assert property (@(posedge pci_free_clk) disable iff (!rst_n)
        (!mode_q && !cpu_stop_n) |=> !cpu_run);

    a_r4_pci_stop_sampled: assert property (@(posedge pci_free_clk) disable iff (!rst_n)
        (!mode_q && !pci_stop_n) |=> !pci_run);

    a_r5_shared_quiet: assert property (@(posedge pci_free_clk) disable iff (!rst_n)
        !mode_q |-> (sd_shared == 2'b00 && !oe_shared));

    a_r7_cpu_rests_low: assert property (@(negedge cpu_src_clk) disable iff (!rst_n)
        !cpu_run |=> !cpu_clk0);

    a_r7_cpu_full_high: assert property (@(negedge cpu_src_clk) disable iff (!rst_n)
        (cpu_run && en_cpu0) |=> cpu_clk0);

    a_r7_pci_rests_low: assert property (@(negedge pci_src_clk) disable iff (!rst_n)
        !pci_run |=> !pci_clk0);

    a_r7_pci_full_high: assert property (@(negedge pci_src_clk) disable iff (!rst_n)
        (pci_run && en_pci0) |=> pci_clk0);
endmodule

bind clkstop_ctrl clkstop_ctrl_chk u_chk (
    .rst_n        (rst_n),
    .pci_free_clk (pci_free_clk),
    .cpu_src_clk  (cpu_src_clk),
    .pci_src_clk  (pci_src_clk),
    .cpu_stop_n   (cpu_stop_n),
    .pci_stop_n   (pci_stop_n),
    .mode_q       (mode_q),
    .cpu_run      (cpu_run),
    .pci_run      (pci_run),
    .en_cpu0      (en_cpu[0]),
    .cpu_clk0     (cpu_clk[0]),
    .en_pci0      (en_pci[0]),
    .pci_clk0     (pci_clk[0]),
    .sd_shared    (sdram_clk[N_SDRAM-1:N_SDRAM-2]),
    .oe_shared    (oe_shared)
);

// File: tb/test_clkstop_ctrl.sv
`timescale 1ns/1ps

// Counts phases of sig shorter than min_w once armed.
module pulse_mon (
    input  logic sig,
    input  logic arm,
    input  real  min_w,
    output int   short_cnt
);
    realtime last_t;
    bit      have_last;
    initial begin short_cnt = 0; have_last = 0; last_t = 0; end
    always @(sig) begin
        if (arm) begin
            if (have_last && ($realtime - last_t) < (min_w - 0.001))
                short_cnt++;
            have_last = 1;
            last_t    = $realtime;
        end else begin
            have_last = 0;
        end
    end
endmodule

module test_clkstop_ctrl;
    localparam int CLK_PERIOD = 20;           // free-running bus clock
    localparam int FAST_HALF  = CLK_PERIOD / 4;
    localparam int REF_HALF   = 28;
    localparam int NB         = 26;
    // Output bit map: cpu 3:0, agp 5:4, pci 10:6, pcif 11, sdram 23:12, ref 25:24
    localparam logic [NB-1:0] CPU_MASK    = 26'h000003F;
    localparam logic [NB-1:0] PCI_MASK    = 26'h00007C0;
    localparam logic [NB-1:0] SHARED_MASK = 26'h0C00000;
    localparam logic [NB-1:0] ALL_ONES    = 26'h3FFFFFF;
    // {cpu_stop_n, pci_stop_n, enables}
    localparam logic [NB+1:0] VEC [8] = '{
        {2'b11, 26'h3FFFFFF}, {2'b01, 26'h3FFFFFF},
        {2'b10, 26'h3FFFFFF}, {2'b00, 26'h3FFFFFF},
        {2'b11, 26'h2AAAAAA}, {2'b01, 26'h1555555},
        {2'b11, 26'h0000000}, {2'b10, 26'h3FFF0F0}
    };

    logic pci_free_clk = 1'b0, cpu_src_clk = 1'b0, agp_src_clk = 1'b0;
    logic sdram_src_clk = 1'b0, ref_src_clk = 1'b0;
    logic pci_src_clk;
    logic rst_n = 1'b0, strap_mode = 1'b0, cpu_stop_n = 1'b1, pci_stop_n = 1'b1, tri_all = 1'b0;
    logic [NB-1:0] en_all = ALL_ONES;
    logic [3:0] cpu_clk; logic [1:0] agp_clk; logic [4:0] pci_clk; logic pcif_clk;
    logic [11:0] sdram_clk; logic [1:0] ref_clk; logic oe_main, oe_shared;
    logic [NB-1:0] outs, seen;
    logic clr = 1'b0, smp = 1'b0, arm = 1'b0;
    int tests = 0, fails = 0;
    bit done = 0;
    int sh_cpu, sh_agp, sh_pci, sh_sd, sh_ref;

    always #(CLK_PERIOD/2) pci_free_clk = ~pci_free_clk;
    always #(FAST_HALF) cpu_src_clk = ~cpu_src_clk;
    always #(FAST_HALF) agp_src_clk = ~agp_src_clk;
    always #(FAST_HALF) sdram_src_clk = ~sdram_src_clk;
    always #(REF_HALF) ref_src_clk = ~ref_src_clk;
    always #1 smp = ~smp;
    assign pci_src_clk = pci_free_clk;
    assign outs = {ref_clk, sdram_clk, pcif_clk, pci_clk, agp_clk, cpu_clk};

    clkstop_ctrl i_clkstop_ctrl (
        .rst_n(rst_n), .pci_free_clk(pci_free_clk), .cpu_src_clk(cpu_src_clk),
        .agp_src_clk(agp_src_clk), .pci_src_clk(pci_src_clk),
        .sdram_src_clk(sdram_src_clk), .ref_src_clk(ref_src_clk),
        .strap_mode(strap_mode), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .tri_all(tri_all), .en_cpu(en_all[3:0]), .en_agp(en_all[5:4]),
        .en_pci(en_all[10:6]), .en_pcif(en_all[11]), .en_sdram(en_all[23:12]),
        .en_ref(en_all[25:24]), .cpu_clk(cpu_clk), .agp_clk(agp_clk),
        .pci_clk(pci_clk), .pcif_clk(pcif_clk), .sdram_clk(sdram_clk),
        .ref_clk(ref_clk), .oe_main(oe_main), .oe_shared(oe_shared)
    );

    pulse_mon m_cpu (.sig(cpu_clk[0]),   .arm(arm), .min_w(real'(FAST_HALF)),    .short_cnt(sh_cpu));
    pulse_mon m_agp (.sig(agp_clk[0]),   .arm(arm), .min_w(real'(FAST_HALF)),    .short_cnt(sh_agp));
    pulse_mon m_pci (.sig(pci_clk[0]),   .arm(arm), .min_w(real'(CLK_PERIOD/2)), .short_cnt(sh_pci));
    pulse_mon m_sd  (.sig(sdram_clk[0]), .arm(arm), .min_w(real'(FAST_HALF)),    .short_cnt(sh_sd));
    pulse_mon m_ref (.sig(ref_clk[0]),   .arm(arm), .min_w(real'(REF_HALF)),     .short_cnt(sh_ref));

    // Records which outputs were seen high since the last clear.
    always @(posedge smp) seen <= clr ? '0 : (seen | outs);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic window();
        clr = 1'b1; #4; clr = 1'b0;
        #(4*CLK_PERIOD);
    endtask

    function automatic logic [NB-1:0] model(input logic [NB+1:0] v, input bit mode1);
        logic [NB-1:0] r = v[NB-1:0];
        if (!mode1) begin
            r &= ~SHARED_MASK;
            if (!v[NB+1]) r &= ~CPU_MASK;
            if (!v[NB])   r &= ~PCI_MASK;
        end
        return r;
    endfunction

    initial begin
        #(CLK_PERIOD*50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: outputs low throughout reset
        #(3*CLK_PERIOD);
        window();
        check(seen == '0, "R1 reset", 32'(seen), 32'h0);
        @(posedge pci_free_clk); #1; rst_n = 1'b1; arm = 1'b1;

        // R2 R3 R4 R5: table walk in strap mode 0
        foreach (VEC[i]) begin
            {cpu_stop_n, pci_stop_n, en_all} = VEC[i];
            #(3*CLK_PERIOD);
            window();
            check(seen == model(VEC[i], 0), "R2 R3 R4 R5 table", 32'(seen), 32'(model(VEC[i], 0)));
        end
        check(oe_shared == 1'b0, "R5 shared pads off in mode 0", 32'(oe_shared), 32'h0);

        // R6 R8: stop placed right after a sampling edge
        en_all = ALL_ONES; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        #(3*CLK_PERIOD);
        @(posedge pci_free_clk); #1;
        cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
        #16; check(cpu_clk[0] == 1'b1, "R6 cpu before sample", 32'(cpu_clk[0]), 32'h1);
        #10; check(cpu_clk[0] == 1'b1 && pci_clk[0] == 1'b1, "R6 last full high", 32'({cpu_clk[0], pci_clk[0]}), 32'h3);
        #10; check(cpu_clk[0] == 1'b0 && agp_clk[0] == 1'b0, "R8 cpu stop latency", 32'({cpu_clk[0], agp_clk[0]}), 32'h0);
        #10; check(pci_clk[0] == 1'b0, "R8 pci stop latency", 32'(pci_clk[0]), 32'h0);
        check(pcif_clk == 1'b1, "R4 free bus clock runs", 32'(pcif_clk), 32'h1);
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        #25; check(cpu_clk[0] == 1'b0, "R6 no restart before falling edge", 32'(cpu_clk[0]), 32'h0);
        #5;  check(cpu_clk[0] == 1'b1, "R8 cpu restart latency", 32'(cpu_clk[0]), 32'h1);
        #5;  check(pci_clk[0] == 1'b1, "R8 pci restart latency", 32'(pci_clk[0]), 32'h1);

        // R9: tristate releases pads, clocks keep running
        #(2*CLK_PERIOD);
        tri_all = 1'b1; #3;
        check(oe_main == 1'b0 && oe_shared == 1'b0, "R9 pads released", 32'({oe_main, oe_shared}), 32'h0);
        window();
        check(seen == (ALL_ONES & ~SHARED_MASK), "R9 clocks still run", 32'(seen), 32'(ALL_ONES & ~SHARED_MASK));
        tri_all = 1'b0;

        // R5: strap 1 latched in reset; later strap change and stop pins ignored
        arm = 1'b0; rst_n = 1'b0; strap_mode = 1'b1;
        #(3*CLK_PERIOD);
        @(posedge pci_free_clk); #1; rst_n = 1'b1; arm = 1'b1;
        strap_mode = 1'b0; cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
        #(3*CLK_PERIOD);
        window();
        check(seen == ALL_ONES, "R5 mode 1 ignores stops", 32'(seen), 32'(ALL_ONES));
        check(oe_shared == 1'b1, "R5 shared pads driven", 32'(oe_shared), 32'h1);

        // R7: no runt or truncated phase seen by any monitor
        check((sh_cpu + sh_agp + sh_pci + sh_sd + sh_ref) == 0, "R7 pulse widths",
              32'(sh_cpu + sh_agp + sh_pci + sh_sd + sh_ref), 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule